// File: doc/BRIEF.md
# Packed-Control Performance Monitor

This block counts hardware activity for profiling. It has one cycle counter and two event counters. All of its control sits in one packed 32-bit control/status word. That word holds the global count enable, one-shot counter clears, a divided cycle-count mode, interrupt enables, sticky overflow flags and two 8-bit event selectors.

A simple register port reaches the control word and the three counters. The port has a write strobe, a 2-bit word address and a combinational read. Event sources drive a vector with one line per event code. Each event counter adds one in every clock in which its selected line is high and counting is enabled.

A counter that wraps past all ones raises its overflow flag. A level interrupt is asserted while any raised flag has its enable set. Software clears a flag by writing 1 to it.

Top module: `packed_ctrl_pmu`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: Register address 0 returns the control word. Its layout is:
  - bit 0: enable
  - bit 3: divided mode
  - bits 6:4: interrupt enables for event counter 0, event counter 1 and the cycle counter
  - bits 10:8: overflow flags, in the same counter order
  - bits 19:12: event code for event counter 0
  - bits 27:20: event code for event counter 1
  
  Bits 1, 2, 7, 11 and 31:28 always read 0, whatever was written.
- R3: While the enable bit is 0, no counter changes unless it is written or cleared.
- R4: Writing 1 to control bit 1 clears both event counters at that clock edge. Writing 1 to control bit 2 clears the cycle counter and the divider phase. Neither bit is stored.
- R5: With enable set and bit 3 clear, the cycle counter adds one every clock. With bit 3 set, it adds one once per 64 enabled clocks. After a write that sets enable, divided mode and the cycle clear together, the counter first reads 1 after the 64th following clock edge.
- R6: An enabled event counter adds one in each clock in which `eventVec[code]` is high. A code of `NUM_EVT` (23) or more, including 0xFF, never counts.
- R7: When a counter increments from 0xFFFFFFFF to 0, its overflow flag is set at the same edge.
- R8: Writing 1 to a flag bit of the control word clears that flag. Writing 0 leaves it unchanged. A wrap in the same cycle keeps the flag set.
- R9: `irq` is high exactly when some overflow flag and its matching interrupt enable are both 1.
- R10: Addresses 1, 2 and 3 read and write the cycle counter, event counter 0 and event counter 1. A register write takes priority over a clear or an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| eventVec | input | NUM_EVT | One pulse line per event code |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted divider phase shows on the cycle counter read within at most 64 enabled clocks. A wrong selector or a missed hit shows as a count off by one at the next read of that counter.

Flag or enable corruption shows on `irq` and on control-word bits 10:8 in the cycle after the edge where it occurs. The bench follows every cycle of a random run with a reference model, so any such divergence is reported within one clock.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 8;
  localparam int NUM_EC = 2;            // event counters
  localparam int NUM_C  = NUM_EC + 1;   // plus cycle counter

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CYC  = 2'd1;
  localparam logic [1:0] ADDR_EV0  = 2'd2;
  localparam logic [1:0] ADDR_EV1  = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_RSTE = 1;
  localparam int B_RSTC = 2;
  localparam int B_DIV  = 3;
  localparam int B_IEN  = 4;   // 3 bits: ev0, ev1, cyc
  localparam int B_FLG  = 8;   // 3 bits: ev0, ev1, cyc
  localparam int B_SEL0 = 12;
  localparam int B_SEL1 = 20;
  localparam logic [DATA_W-1:0] RSVD_MASK = 32'hF000_0886;

  typedef struct packed {
    logic                          countEn;
    logic                          divMode;
    logic                          rstEv;
    logic                          rstCyc;
    logic                          wrCyc;
    logic [NUM_EC-1:0]             wrEv;
    logic [NUM_EC-1:0][SEL_W-1:0]  evSel;
  } pmu_strobe_t;
endpackage

// File: rtl/pmu_ctrl.sv
`timescale 1ns/1ps
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [NUM_C-1:0]  ovfPulse,
  output pmu_strobe_t       strobe,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              irq
);
  logic enReg, divReg;
  logic [NUM_C-1:0] ienReg, flagReg;
  logic [NUM_EC-1:0][SEL_W-1:0] selReg;
  logic wrCtrl;
  logic [NUM_C-1:0] clrMask;
  logic unusedBits;

  assign wrCtrl     = regWrEn && (regAddr == ADDR_CTRL);
  assign clrMask    = wrCtrl ? regWrData[B_FLG +: NUM_C] : '0;
  assign unusedBits = ^{regWrData[31:28], regWrData[11], regWrData[7]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      divReg  <= 1'b0;
      ienReg  <= '0;
      flagReg <= '0;
      selReg  <= '0;
    end else begin
      flagReg <= (flagReg & ~clrMask) | ovfPulse;
      if (wrCtrl) begin
        enReg     <= regWrData[B_EN];
        divReg    <= regWrData[B_DIV];
        ienReg    <= regWrData[B_IEN +: NUM_C];
        selReg[0] <= regWrData[B_SEL0 +: SEL_W];
        selReg[1] <= regWrData[B_SEL1 +: SEL_W];
      end
    end
  end

  always_comb begin
    strobe.countEn = enReg;
    strobe.divMode = divReg;
    strobe.rstEv   = wrCtrl && regWrData[B_RSTE];
    strobe.rstCyc  = wrCtrl && regWrData[B_RSTC];
    strobe.wrCyc   = regWrEn && (regAddr == ADDR_CYC);
    strobe.wrEv[0] = regWrEn && (regAddr == ADDR_EV0);
    strobe.wrEv[1] = regWrEn && (regAddr == ADDR_EV1);
    strobe.evSel   = selReg;
  end

  assign ctrlWord = {4'b0, selReg[1], selReg[0], 1'b0, flagReg, 1'b0,
                     ienReg, divReg, 2'b00, enReg};
  assign irq = |(flagReg & ienReg);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ovfPulse) |=> ((flagReg & $past(ovfPulse)) == $past(ovfPulse)));
  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[B_FLG] && !ovfPulse[0]) |=> !flagReg[0]);
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(|ovfPulse) || $past(wrCtrl)));
endmodule

// File: rtl/pmu_datapath.sv
`timescale 1ns/1ps
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 23,
  parameter int DIV_LOG2 = 6
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  pmu_strobe_t                  strobe,
  input  logic [CNT_W-1:0]             wrData,
  input  logic [NUM_EVT-1:0]           eventVec,
  output logic [CNT_W-1:0]             cycCnt,
  output logic [NUM_EC-1:0][CNT_W-1:0] evCnt,
  output logic [NUM_C-1:0]             ovfPulse
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  logic [DIV_LOG2-1:0] prePhase;
  logic preWrap, cycInc;

  assign preWrap = &prePhase;
  assign cycInc  = strobe.countEn && (!strobe.divMode || preWrap);
  assign ovfPulse[NUM_EC] = cycInc && !strobe.wrCyc && !strobe.rstCyc && (&cycCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prePhase <= '0;
      cycCnt   <= '0;
    end else begin
      if (strobe.rstCyc)      prePhase <= '0;
      else if (strobe.countEn) prePhase <= prePhase + DIV_LOG2'(1);
      if (strobe.wrCyc)       cycCnt <= wrData;
      else if (strobe.rstCyc) cycCnt <= '0;
      else if (cycInc)        cycCnt <= cycCnt + CNT_ONE;
    end
  end

  for (genvar g = 0; g < NUM_EC; g++) begin : g_ev
    logic hit, inc;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_EVT; k++)
        if (strobe.evSel[g] == SEL_W'(k)) hit = eventVec[k];
    end
    assign inc = strobe.countEn && hit;
    assign ovfPulse[g] = inc && !strobe.wrEv[g] && !strobe.rstEv && (&evCnt[g]);

    always_ff @(posedge clk) begin
      if (!rstN)               evCnt[g] <= '0;
      else if (strobe.wrEv[g]) evCnt[g] <= wrData;
      else if (strobe.rstEv)   evCnt[g] <= '0;
      else if (inc)            evCnt[g] <= evCnt[g] + CNT_ONE;
    end

    // R3
    ev_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.countEn && !strobe.wrEv[g] && !strobe.rstEv) |=> $stable(evCnt[g]));
    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrEv[g] |=> (evCnt[g] == $past(wrData)));
    // R6
    unused_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((strobe.evSel[g] >= SEL_W'(NUM_EVT)) && !strobe.wrEv[g] && !strobe.rstEv)
        |=> $stable(evCnt[g]));
  end

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.divMode && !preWrap && !strobe.wrCyc && !strobe.rstCyc) |=> $stable(cycCnt));
  // R3
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.wrCyc && !strobe.rstCyc) |=> $stable(cycCnt));
endmodule

// File: rtl/packed_ctrl_pmu.sv
`timescale 1ns/1ps
module packed_ctrl_pmu
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 23,
  parameter int DIV_LOG2 = 6
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_EVT-1:0] eventVec,
  output logic               irq
);
  pmu_strobe_t strobe;
  logic [NUM_C-1:0] ovfPulse;
  logic [DATA_W-1:0] ctrlWord;
  logic [CNT_W-1:0] cycCnt;
  logic [NUM_EC-1:0][CNT_W-1:0] evCnt;

  pmu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ovfPulse(ovfPulse), .strobe(strobe),
    .ctrlWord(ctrlWord), .irq(irq)
  );

  pmu_datapath #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .DIV_LOG2(DIV_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData[CNT_W-1:0]),
    .eventVec(eventVec), .cycCnt(cycCnt), .evCnt(evCnt), .ovfPulse(ovfPulse)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = ctrlWord;
      ADDR_CYC:  regRdData = DATA_W'(cycCnt);
      ADDR_EV0:  regRdData = DATA_W'(evCnt[0]);
      default:   regRdData = DATA_W'(evCnt[1]);
    endcase
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> ((regRdData & RSVD_MASK) == '0));
endmodule

// File: tb/tb_packed_ctrl_pmu.sv
`timescale 1ns/1ps
module tb_packed_ctrl_pmu;
  localparam int NEV = 23;
  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, irq;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic [NEV-1:0] eventVec = '0;
  int checks = 0, fails = 0;

  packed_ctrl_pmu #(.CNT_W(32), .NUM_EVT(NEV), .DIV_LOG2(6)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .eventVec(eventVec), .irq(irq));

  always #10 clk = ~clk;

  // reference model, written from the requirements
  logic [31:0] mCyc, mEv0, mEv1;
  logic [5:0] mPre;
  logic mEn, mDiv;
  logic [2:0] mIen, mFlag;
  logic [7:0] mSel0, mSel1;
  logic wc, wcy, we0, we1, rE, rC, tick, h0, h1, o0, o1, oc;

  function automatic logic hitOf(logic [7:0] s);
    for (int k = 0; k < NEV; k++) if (s == 8'(k)) return eventVec[k];
    return 1'b0;
  endfunction

  function automatic logic [31:0] expCtrl();
    return {4'b0, mSel1, mSel0, 1'b0, mFlag, 1'b0, mIen, mDiv, 2'b00, mEn};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCyc = 0; mEv0 = 0; mEv1 = 0; mPre = 0; mEn = 0; mDiv = 0;
      mIen = 0; mFlag = 0; mSel0 = 0; mSel1 = 0;
    end else begin
      wc  = regWrEn && regAddr == 2'd0;
      wcy = regWrEn && regAddr == 2'd1;
      we0 = regWrEn && regAddr == 2'd2;
      we1 = regWrEn && regAddr == 2'd3;
      rE  = wc && regWrData[1];
      rC  = wc && regWrData[2];
      tick = mEn && (!mDiv || mPre == 6'h3F);
      h0 = mEn && hitOf(mSel0);
      h1 = mEn && hitOf(mSel1);
      o0 = h0 && !we0 && !rE && mEv0 == 32'hFFFF_FFFF;
      o1 = h1 && !we1 && !rE && mEv1 == 32'hFFFF_FFFF;
      oc = tick && !wcy && !rC && mCyc == 32'hFFFF_FFFF;
      mFlag = (mFlag & ~(wc ? regWrData[10:8] : 3'b0)) | {oc, o1, o0};
      mEv0 = we0 ? regWrData : rE ? 32'd0 : h0 ? mEv0 + 1 : mEv0;
      mEv1 = we1 ? regWrData : rE ? 32'd0 : h1 ? mEv1 + 1 : mEv1;
      mCyc = wcy ? regWrData : rC ? 32'd0 : tick ? mCyc + 1 : mCyc;
      mPre = rC ? 6'd0 : mEn ? mPre + 6'd1 : mPre;
      if (wc) begin
        mEn = regWrData[0]; mDiv = regWrData[3]; mIen = regWrData[6:4];
        mSel0 = regWrData[19:12]; mSel1 = regWrData[27:20];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmpAll(input string tag);
    logic [31:0] v;
    rd(2'd0, v); chk({tag, " ctrl"}, v, expCtrl());
    rd(2'd1, v); chk({tag, " cyc"}, v, mCyc);
    rd(2'd2, v); chk({tag, " ev0"}, v, mEv0);
    rd(2'd3, v); chk({tag, " ev1"}, v, mEv1);
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(mFlag & mIen)});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL WDOG: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v, c0;
    int seedInit;
    seedInit = $urandom(32'd4242);
    idle(3); rstN = 1'b1; idle(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 cyc", v, 0);
    rd(2'd2, v); chk("R1 ev0", v, 0);
    rd(2'd3, v); chk("R1 ev1", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 reserved and pulse bits read zero
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 ctrl mask", v, 32'h0FFF_F079);
    wr(2'd0, 32'h0);

    // R6 unused codes do not count; valid code at bit position counts
    wr(2'd2, 32'd5); wr(2'd3, 32'd9);
    wr(2'd0, 32'h017F_F001);
    eventVec = '1; idle(5);
    rd(2'd2, v); chk("R6 ev0 code FF", v, 32'd5);
    rd(2'd3, v); chk("R6 ev1 code 17", v, 32'd9);
    eventVec = '0;
    wr(2'd0, 32'h0001_6001);
    eventVec = '1; idle(4);
    rd(2'd2, v); chk("R6 ev0 code 16", v, 32'd9);
    rd(2'd3, v); chk("R6 ev1 code 00", v, 32'd13);

    // R10 write wins over increment
    @(negedge clk); regWrEn = 1'b1; regAddr = 2'd2; regWrData = 32'h100;
    @(negedge clk); regWrEn = 1'b0;
    rd(2'd2, v); chk("R10 write priority", v, 32'h100);
    eventVec = '0;

    // R3 hold while disabled
    wr(2'd0, 32'h0001_6000);
    rd(2'd1, c0);
    eventVec = '1; idle(5);
    rd(2'd1, v); chk("R3 cyc hold", v, c0);
    rd(2'd2, v); chk("R3 ev0 hold", v, mEv0);
    eventVec = '0;

    // R4 clear pulses
    wr(2'd0, 32'h2);
    rd(2'd2, v); chk("R4 ev0 cleared", v, 0);
    rd(2'd3, v); chk("R4 ev1 cleared", v, 0);
    rd(2'd1, v); chk("R4 cyc kept", v, c0);
    wr(2'd0, 32'h4);
    rd(2'd1, v); chk("R4 cyc cleared", v, 0);
    rd(2'd0, v); chk("R4 bits self-clear", v, 0);

    // R10 counters read back
    wr(2'd1, 32'hDEAD_0001); wr(2'd3, 32'h1234_5678);
    rd(2'd1, v); chk("R10 cyc rw", v, 32'hDEAD_0001);
    rd(2'd3, v); chk("R10 ev1 rw", v, 32'h1234_5678);

    // R7 event overflow, R9 irq, R8 clear
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0000_5011);
    eventVec[5] = 1'b1; idle(1); eventVec = '0;
    rd(2'd2, v); chk("R7 ev0 wrapped", v, 0);
    rd(2'd0, v); chk("R7 flag ev0", v, 32'h0000_5111);
    chk("R9 irq set", {31'd0, irq}, 1);
    wr(2'd0, 32'h0000_5011);
    rd(2'd0, v); chk("R8 write 0 keeps", v, 32'h0000_5111);
    wr(2'd0, 32'h0000_5111);
    rd(2'd0, v); chk("R8 w1c", v, 32'h0000_5011);
    chk("R9 irq clear", {31'd0, irq}, 0);

    // R7 cycle overflow
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_FFFE);
    wr(2'd0, 32'h41);
    idle(2);
    rd(2'd1, v); chk("R7 cyc wrapped", v, 0);
    rd(2'd0, v); chk("R7 flag cyc", v, 32'h441);
    chk("R9 irq cyc", {31'd0, irq}, 1);
    wr(2'd0, 32'h400);
    chk("R9 irq off", {31'd0, irq}, 0);

    // R5 divided mode
    wr(2'd0, 32'h0D);
    idle(63);
    rd(2'd1, v); chk("R5 before 64", v, 0);
    idle(1);
    rd(2'd1, v); chk("R5 at 64", v, 1);
    rd(2'd0, v); chk("R5 ctrl", v, 32'h9);
    cmpAll("SYNC");

    // random run against model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      cmpAll("RND");
      eventVec = NEV'($urandom);
      if ($urandom % 8 == 0) begin
        regWrEn = 1'b1;
        regAddr = 2'($urandom % 4);
        v = $urandom;
        if (regAddr == 2'd0) begin
          v[19:12] = 8'($urandom % 32);
          v[27:20] = 8'($urandom % 32);
          v[0] = ($urandom % 4) != 0;
          v[3] = ($urandom % 4) == 0;
        end else if ($urandom % 2 == 0) begin
          v = 32'hFFFF_FFF0 | ($urandom % 16);
        end
        regWrData = v;
      end
    end
    @(negedge clk); regWrEn = 1'b0;
    cmpAll("END");
    summary();
  end
endmodule